// File: doc/BRIEF.md
# LCD Common-Scan Timing Generator

This block produces the timing that walks a segment LCD through its common (backplane) lines. A base clock is divided by a selectable power of two, and each divided tick moves the active common to the next one. The number of commons scanned per frame follows the multiplexing duty: four, three, two or one. Each time common 0 begins its slot, a frame-start strobe marks it. Commons that the chosen duty leaves unused are flagged as extra segment outputs, so the pad logic can repurpose them.

A single 6-bit control register holds all the settings: display on/off, a booster enable bit, the duty and the clock divide. The booster bit only reaches an output pin. It has no effect on timing. When the display is off, the divider and the scan counter stay at zero and every common output is inactive. If software changes the duty or the divide while the display is running, the slot in progress is allowed to finish. The scan then restarts cleanly from common 0, so it never points at a common that the new duty does not use.

Top module: `lcd_scan_gen`

## Requirements
- R1: After reset, the register reads 0x00, `com_act` is 0, `frame_start` is 0 and `boost_en` is 0.
- R2: A write on `cfg_wr` stores `cfg_wdata[5:0]` at the next clock edge. The bit fields are: bit 5 display on, bit 4 booster enable, bits 3:2 duty, bits 1:0 divide. `cfg_rdata[7:6]` always reads 0.
- R3: Each common slot lasts 32 << divide base-clock cycles, so divide codes 0 to 3 give 32, 64, 128 and 256.
- R4: The duty code sets the commons scanned in ascending order from common 0, wrapping after the last one: 0 gives four commons, 1 gives three, 2 gives two and 3 gives one.
- R5: `com_act` has at most one bit set, and bit i stands for common i.
- R6: `frame_start` is high for exactly the first base cycle of each common-0 slot. Its period is slot length times the number of scanned commons.
- R7: `com_seg_flag[k]` marks common k+1 as reassigned to segment use. Duty 0 gives 000, duty 1 gives 100, duty 2 gives 110 and duty 3 gives 111. A reassigned common is never active outside a pending restart.
- R8: With display on at 0, `com_act` is 0 and `frame_start` is 0. Turning the display on starts the scan at common 0 with a fresh slot, and `frame_start` is high in the first cycle after the enabling edge.
- R9: `boost_en` follows register bit 4, and writing that bit leaves the scan sequence untouched.
- R10: A write that changes the duty or divide leaves the current common active until the divider count reaches the new slot length minus one, or has already passed it. On the next edge after that, the scan returns to common 0 with a fresh slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data (bits 7:6 ignored) |
| cfg_rdata | output | 8 | Control register contents, bits 7:6 zero |
| com_act | output | 4 | One-hot active common |
| frame_start | output | 1 | One-cycle strobe at the start of the common-0 slot |
| com_seg_flag | output | 3 | Bit k set: common k+1 serves as a segment output |
| boost_en | output | 1 | Voltage booster enable |

## Verification
The checker relies on register writes lasting exactly one cycle, with reset held for whole cycles. It makes no assumption about when a write lands relative to a divider tick. The only exception is the stability and pending-clear properties, which waive the cycle after a write. The bench drives every write for one cycle on a falling edge. Its restart cases place the write at known divider counts: one while the old slot is mid-count, and one where the count already exceeds the new limit. This means both branches of the restart rule are reached on purpose.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int unsigned COM_N = 4;

  typedef struct packed {
    logic       lcd_on;
    logic       boost;
    logic [1:0] duty;
    logic [1:0] div_sel;
  } lcd_cfg_t;

  // Base cycles per common slot for a divide code.
  function automatic int unsigned slot_len(input logic [1:0] div_sel,
                                           input int unsigned base_log2);
    return 32'd1 << (base_log2 + int'(div_sel));
  endfunction

  // Number of commons scanned per frame for a duty code (4,3,2,1).
  function automatic logic [2:0] coms_in_frame(input logic [1:0] duty);
    return 3'd4 - {1'b0, duty};
  endfunction

  // Commons 3..1 handed over to segment duty.
  function automatic logic [2:0] seg_takeover(input logic [1:0] duty);
    logic [2:0] m;
    case (duty)
      2'd0:    m = 3'b000;
      2'd1:    m = 3'b100;
      2'd2:    m = 3'b110;
      default: m = 3'b111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lcd_cfg_reg.sv
module lcd_cfg_reg
  import lcd_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] wr_data,
  output lcd_cfg_t   cfg,
  output logic       timing_chg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= lcd_cfg_t'(wr_data);
  end

  // Duty or divide field differs from the stored value.
  assign timing_chg = wr_en && (wr_data[3:0] != {cfg.duty, cfg.div_sel});

endmodule

// File: rtl/lcd_prescaler.sv
module lcd_prescaler
  import lcd_scan_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 5,
  localparam int unsigned PRE_W    = BASE_LOG2 + 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick,
  output logic       cnt_zero
);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] limit;

  assign limit    = PRE_W'(slot_len(div_sel, BASE_LOG2) - 1);
  // ">=" covers a count left beyond a freshly shortened slot.
  assign tick     = run && (cnt >= limit);
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             timing_chg,
  input  logic [1:0]       duty,
  output logic [COM_N-1:0] com_act,
  output logic             idx_zero,
  output logic             restart_pend
);

  logic [1:0] idx;
  logic [2:0] idx_inc;
  logic       wrap;

  assign idx_inc  = {1'b0, idx} + 3'd1;
  assign wrap     = restart_pend || (idx_inc >= coms_in_frame(duty));
  assign idx_zero = (idx == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          restart_pend <= 1'b0;
    else if (!run)       restart_pend <= 1'b0;
    else if (timing_chg) restart_pend <= 1'b1;
    else if (tick)       restart_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (!run) idx <= '0;
    else if (tick) idx <= wrap ? 2'd0 : idx_inc[1:0];
  end

  for (genvar i = 0; i < COM_N; i++) begin : g_com
    assign com_act[i] = run && (idx == 2'(i));
  end

endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen
  import lcd_scan_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic [3:0] com_act,
  output logic       frame_start,
  output logic [2:0] com_seg_flag,
  output logic       boost_en
);

  lcd_cfg_t cfg;
  logic     timing_chg;
  logic     run;
  logic     tick;
  logic     pre_zero;
  logic     idx_zero;
  logic     restart_pend;

  lcd_cfg_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr),
    .wr_data    (cfg_wdata[5:0]),
    .cfg        (cfg),
    .timing_chg (timing_chg)
  );

  assign run = cfg.lcd_on;

  lcd_prescaler #(.BASE_LOG2(BASE_LOG2)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div_sel  (cfg.div_sel),
    .tick     (tick),
    .cnt_zero (pre_zero)
  );

  lcd_com_scan u_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .tick         (tick),
    .timing_chg   (timing_chg),
    .duty         (cfg.duty),
    .com_act      (com_act),
    .idx_zero     (idx_zero),
    .restart_pend (restart_pend)
  );

  assign frame_start  = run && idx_zero && pre_zero;
  assign com_seg_flag = seg_takeover(cfg.duty);
  assign boost_en     = cfg.boost;
  assign cfg_rdata    = {2'b00, cfg};

endmodule

// File: rtl/lcd_scan_gen_chk.sv
module lcd_scan_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       run,
  input logic       tick,
  input logic       restart_pend,
  input logic [3:0] com_act,
  input logic       frame_start,
  input logic [2:0] com_seg_flag
);

  // R5
  com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_act));

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (com_act == 4'b0 && !frame_start));

  // R6
  frame_com0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> com_act[0]);

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !cfg_wr) |=> $stable(com_act));

  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_wr) |=> !restart_pend);

  // R7
  seg_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_pend |-> ((com_act[3:1] & com_seg_flag) == 3'b0));

endmodule

bind lcd_scan_gen lcd_scan_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .run          (run),
  .tick         (tick),
  .restart_pend (restart_pend),
  .com_act      (com_act),
  .frame_start  (frame_start),
  .com_seg_flag (com_seg_flag)
);

// File: tb/lcd_scan_gen_bench.sv
`timescale 1ns/1ps
module lcd_scan_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [3:0] com_act;
  logic       frame_start;
  logic [2:0] com_seg_flag;
  logic       boost_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_scan_gen u_lcd_scan_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .com_act      (com_act),
    .frame_start  (frame_start),
    .com_seg_flag (com_seg_flag),
    .boost_en     (boost_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Called at a falling edge; captured at the next rising edge.
  // Returns at the falling edge after that edge.
  task automatic write(input logic [7:0] d);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int slot_cyc(input int sel);
    return 32 * (2 ** sel);
  endfunction

  function automatic logic [2:0] exp_flags(input int duty);
    logic [2:0] f = 3'b000;
    for (int k = 0; k < 3; k++) if (3 - k <= duty) f[k] = 1'b1;
    return f;
  endfunction

  // R3 R4 R6 R7 R8: sweep one divide/duty pair from a disabled start.
  task automatic sweep(input int sel, input int duty);
    int slot, ncom, bad_com, bad_fs, n_fs;
    logic [3:0] exp_c;
    slot = slot_cyc(sel);
    ncom = 4 - duty;
    write(8'h00);
    chk(com_act == 4'b0, "R8 disabled com", com_act, 0);
    write(8'h20 | 8'(duty << 2) | 8'(sel));
    chk(com_seg_flag == exp_flags(duty), "R7 seg flags", com_seg_flag,
        exp_flags(duty));
    bad_com = 0; bad_fs = 0; n_fs = 0;
    for (int t = 0; t < 2 * slot * ncom; t++) begin
      exp_c = 4'b1 << ((t / slot) % ncom);
      if (com_act != exp_c) bad_com++;
      if (frame_start != ((t % (slot * ncom)) == 0)) bad_fs++;
      if (frame_start) n_fs++;
      step(1);
    end
    chk(bad_com == 0, "R3/R4 common sequence", bad_com, 0);
    chk(bad_fs == 0 && n_fs == 2, "R6 frame strobe", n_fs, 2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    step(3);
    // R1
    chk(cfg_rdata == 8'h00, "R1 reg reset", cfg_rdata, 0);
    chk(com_act == 4'b0, "R1 com reset", com_act, 0);
    chk(!frame_start && !boost_en, "R1 strobe/boost reset",
        {frame_start, boost_en}, 0);
    rst_n = 1'b1;
    step(2);

    // R2: fields and unused top bits
    write(8'hFF);
    chk(cfg_rdata == 8'h3F, "R2 readback", cfg_rdata, 8'h3F);
    chk(com_seg_flag == 3'b111, "R7 static flags", com_seg_flag, 3'b111);
    write(8'h96);
    chk(cfg_rdata == 8'h16, "R2 field mask", cfg_rdata, 8'h16);
    chk(boost_en == 1'b1, "R9 boost out", boost_en, 1);

    // R8: disabled with nonzero settings stays quiet
    write(8'h0C);
    bad = 0;
    for (int t = 0; t < 50; t++) begin
      if (com_act != 4'b0 || frame_start) bad++;
      step(1);
    end
    chk(bad == 0, "R8 off stays quiet", bad, 0);

    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        sweep(s, d);

    // R9: booster write mid-scan leaves the sequence alone
    write(8'h00);
    write(8'h20);
    step(40);
    write(8'h30);
    chk(com_act == 4'b0010, "R9 scan after boost write", com_act, 4'b0010);
    chk(boost_en == 1'b1, "R9 boost on", boost_en, 1);
    step(55);
    chk(com_act == 4'b1000, "R9 sequence continues", com_act, 4'b1000);

    // R10: duty change mid-slot restarts on the next tick
    write(8'h00);
    write(8'h20);
    step(69);
    write(8'h28);
    chk(com_act == 4'b0100, "R10 slot kept", com_act, 4'b0100);
    step(25);
    chk(com_act == 4'b0100, "R10 slot kept to end", com_act, 4'b0100);
    step(1);
    chk(com_act == 4'b0001 && frame_start, "R10 restart at common 0",
        {frame_start, com_act}, 5'b10001);
    step(32);
    chk(com_act == 4'b0010, "R10 new duty second common", com_act, 4'b0010);
    step(32);
    chk(com_act == 4'b0001 && frame_start, "R10 new duty wrap",
        {frame_start, com_act}, 5'b10001);

    // R10: divide shortened below the running count
    write(8'h00);
    write(8'h23);
    step(200);
    write(8'h20);
    chk(com_act == 4'b0001 && !frame_start, "R10 count beyond limit",
        {frame_start, com_act}, 5'b00001);
    step(1);
    chk(frame_start == 1'b1, "R10 immediate restart", frame_start, 1);
    step(32);
    chk(com_act == 4'b0010, "R10 short slot", com_act, 4'b0010);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule